// File: doc/BRIEF.md
# Valley-Switching Gate Timing Controller

This block sequences the power switch of a quasi-resonant buck-boost LED converter. The analog side supplies comparator outputs: two supply-level flags, a resonant-valley pulse, an over-current flag and an over-voltage flag. The analog side also supplies an on-time count derived from the loop compensation level. The block decides when the gate turns on and how long it stays on. Its output is a single gate-enable bit, and it reports its operating mode.

After the supply rises past its start level, the block leaves standby. It fires from a slow internal restart timer until the first valley-triggered turn-on. From then on it runs in valley mode: each new cycle begins at the first valley seen while the gate is low. The restart timer is still there as a fallback when no valley arrives. A minimum switching period caps the frequency. An over-current flag can cut an on-time short only inside a window that starts after a blanking interval. An over-voltage flag seen while the gate is low shuts the block down until the supply drops below its stop level.

All times are counts of the system clock, set by parameters: `BLANK_CYC`, `DETECT_CYC`, `MIN_PERIOD_CYC` and `RESTART_CYC`.

Top module: `qr_gate_ctrl`

## Requirements
- R1: After reset, and while `vdd_start_ok` has not yet been seen high, `gate_o` is 0 and `mode_o` is 0 (standby).
- R2: In standby with `vdd_hold_ok` high, `vdd_start_ok` high moves the block to startup (`mode_o`=1) at the next clock edge. The first turn-on comes `RESTART_CYC` cycles after that edge. While no valley arrives, turn-ons then repeat every `RESTART_CYC` cycles.
- R3: `ton_i` is latched at each turn-on. The gate then stays high for that many cycles, and a latched value of 0 counts as 1.
- R4: A `valley_i` pulse sampled while the gate is low turns the gate on at the next edge, provided at least `MIN_PERIOD_CYC` cycles have passed since the last turn-on. The first such turn-on switches `mode_o` to 2 (valley).
- R5: Turn-ons are never closer than `MIN_PERIOD_CYC` cycles. A valley that arrives too early is held, and the gate then turns on exactly `MIN_PERIOD_CYC` cycles after the previous turn-on.
- R6: `valley_i` pulses while the gate is high have no effect.
- R7: Let k be the number of cycles since the gate rose, with k=0 in the first high cycle. `ocp_i` ends the on-time at the next edge only when `BLANK_CYC` <= k < `BLANK_CYC`+`DETECT_CYC`. Outside that window it is ignored.
- R8: In valley mode, when no valley arrives, the next turn-on comes `RESTART_CYC` cycles after the previous one, and the mode stays 2.
- R9: `ovp_i` sampled while running with the gate low moves the block to shutdown (`mode_o`=3) with the gate low. Shutdown is kept even after `ovp_i` clears. If `ovp_i` and a valley fall in the same cycle, the over-voltage wins. `ovp_i` while the gate is high is ignored.
- R10: `vdd_hold_ok` low forces standby and a low gate at the next edge, from any mode. A later start re-times from zero as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| vdd_start_ok | input | 1 | Supply above the start level |
| vdd_hold_ok | input | 1 | Supply above the stop level |
| valley_i | input | 1 | Resonant valley detected (pulse) |
| ocp_i | input | 1 | Switch current above the over-current level |
| ovp_i | input | 1 | Output over-voltage detected |
| ton_i | input | TON_W | On-time in clock cycles, latched at turn-on |
| gate_o | output | 1 | Power switch enable |
| mode_o | output | 2 | 0 standby, 1 startup, 2 valley, 3 shutdown |

## Verification
Two pairs of events can land in one cycle. The first pair is over-voltage and valley: the bench drives a valley pulse and the over-voltage flag on the same gate-low cycle. It expects shutdown with no turn-on, and then no gate pulse for many restart periods. The second pair is an early valley and expiry of the minimum period. The bench sweeps the valley position across every cycle after the gate falls. The next rise must come at the later of one cycle after the pulse and the minimum period, computed arithmetically for each position.

// File: rtl/qr_gate_pkg.sv
package qr_gate_pkg;

    typedef enum logic [1:0] {
        MODE_STANDBY  = 2'd0,
        MODE_STARTUP  = 2'd1,
        MODE_VALLEY   = 2'd2,
        MODE_SHUTDOWN = 2'd3
    } qr_mode_e;

    // Turn-on decision of one cycle
    typedef struct packed {
        logic fire;
        logic from_valley;
        logic hold_valley;
        logic ovp_trip;
    } qr_trig_t;

    function automatic logic is_running(qr_mode_e m);
        return (m == MODE_STARTUP) || (m == MODE_VALLEY);
    endfunction

endpackage

// File: rtl/qr_period_timer.sv
module qr_period_timer #(
    parameter int MIN_CYC     = 312,
    parameter int RESTART_CYC = 10000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    output logic min_ok,
    output logic restart_due
);
    localparam int CW = $clog2(RESTART_CYC + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(RESTART_CYC - 1);
    localparam logic [CW-1:0] MIN_CNT  = CW'(MIN_CYC - 1);

    logic [CW-1:0] cnt_q;

    // Cycles since the last turn-on, saturating at the restart point
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST_CNT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign min_ok      = (cnt_q >= MIN_CNT);
    assign restart_due = (cnt_q == LAST_CNT);
endmodule

// File: rtl/qr_ontime_timer.sv
module qr_ontime_timer #(
    parameter int TON_W      = 8,
    parameter int BLANK_CYC  = 20,
    parameter int DETECT_CYC = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             run,
    input  logic [TON_W-1:0] ton_i,
    input  logic             ocp_i,
    output logic             end_on
);
    localparam int WIN_END = BLANK_CYC + DETECT_CYC;
    localparam int WIN_W   = $clog2(WIN_END + 1);
    localparam int CW      = (TON_W > WIN_W) ? TON_W : WIN_W;

    logic [TON_W-1:0] ton_q;
    logic [CW-1:0]    cnt_q;
    logic [CW-1:0]    last_cnt;
    logic             in_window;

    always_ff @(posedge clk) begin
        if (rst) begin
            ton_q <= '0;
            cnt_q <= '0;
        end else if (start) begin
            ton_q <= ton_i;
            cnt_q <= '0;
        end else if (run && (cnt_q != '1)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        last_cnt  = (ton_q == '0) ? '0 : (CW'(ton_q) - 1'b1);
        in_window = (cnt_q >= CW'(BLANK_CYC)) && (cnt_q < CW'(WIN_END));
        end_on    = run && ((cnt_q >= last_cnt) || (ocp_i && in_window));
    end
endmodule

// File: rtl/qr_gate_ctrl.sv
module qr_gate_ctrl
    import qr_gate_pkg::*;
#(
    parameter int TON_W          = 8,
    parameter int BLANK_CYC      = 20,
    parameter int DETECT_CYC     = 20,
    parameter int MIN_PERIOD_CYC = 312,
    parameter int RESTART_CYC    = 10000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vdd_start_ok,
    input  logic             vdd_hold_ok,
    input  logic             valley_i,
    input  logic             ocp_i,
    input  logic             ovp_i,
    input  logic [TON_W-1:0] ton_i,
    output logic             gate_o,
    output logic [1:0]       mode_o
);
    qr_mode_e mode_q;
    logic     gate_q;
    logic     pend_q;
    logic     min_ok, restart_due, end_on;
    logic     period_clear;
    qr_trig_t trig;

    always_comb begin
        trig             = '0;
        trig.ovp_trip    = is_running(mode_q) && !gate_q && ovp_i;
        trig.from_valley = is_running(mode_q) && !gate_q && !trig.ovp_trip
                           && (valley_i || pend_q) && min_ok;
        trig.fire        = trig.from_valley
                           || (is_running(mode_q) && !gate_q && !trig.ovp_trip && restart_due);
        trig.hold_valley = is_running(mode_q) && !gate_q && !trig.ovp_trip
                           && valley_i && !trig.fire;
        period_clear     = (mode_q == MODE_STANDBY) || trig.fire;
    end

    qr_period_timer #(
        .MIN_CYC     (MIN_PERIOD_CYC),
        .RESTART_CYC (RESTART_CYC)
    ) u_period (
        .clk         (clk),
        .rst         (rst),
        .clear       (period_clear),
        .min_ok      (min_ok),
        .restart_due (restart_due)
    );

    qr_ontime_timer #(
        .TON_W      (TON_W),
        .BLANK_CYC  (BLANK_CYC),
        .DETECT_CYC (DETECT_CYC)
    ) u_ontime (
        .clk    (clk),
        .rst    (rst),
        .start  (trig.fire),
        .run    (gate_q),
        .ton_i  (ton_i),
        .ocp_i  (ocp_i),
        .end_on (end_on)
    );

    always_ff @(posedge clk) begin
        if (rst || !vdd_hold_ok) begin
            mode_q <= MODE_STANDBY;
            gate_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            case (mode_q)
                MODE_STANDBY: begin
                    if (vdd_start_ok) mode_q <= MODE_STARTUP;
                end
                MODE_SHUTDOWN: begin
                    gate_q <= 1'b0;
                end
                default: begin
                    if (trig.ovp_trip) begin
                        mode_q <= MODE_SHUTDOWN;
                        pend_q <= 1'b0;
                    end else if (gate_q) begin
                        if (end_on) gate_q <= 1'b0;
                    end else if (trig.fire) begin
                        gate_q <= 1'b1;
                        pend_q <= 1'b0;
                        if (trig.from_valley) mode_q <= MODE_VALLEY;
                    end else if (trig.hold_valley) begin
                        pend_q <= 1'b1;
                    end
                end
            endcase
        end
    end

    assign gate_o = gate_q;
    assign mode_o = mode_q;
endmodule

// File: rtl/qr_gate_ctrl_chk.sv
module qr_gate_ctrl_chk #(
    parameter int MIN_PERIOD_CYC = 312
) (
    input logic       clk,
    input logic       rst,
    input logic       vdd_hold_ok,
    input logic       ovp_i,
    input logic       gate_o,
    input logic [1:0] mode_o
);
    localparam int GW = $clog2(MIN_PERIOD_CYC + 1);
    localparam logic [GW-1:0] GAP_MAX = GW'(MIN_PERIOD_CYC);

    logic          gate_d;
    logic [GW-1:0] gap_q;
    logic          rise_now;

    assign rise_now = gate_o && !gate_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_d <= 1'b0;
            gap_q  <= GAP_MAX;
        end else begin
            gate_d <= gate_o;
            if (rise_now)            gap_q <= GW'(1);
            else if (gap_q != GAP_MAX) gap_q <= gap_q + 1'b1;
        end
    end

    p_standby_gate_low_r1: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd0) |-> !gate_o);

    p_min_period_r5: assert property (@(posedge clk) disable iff (rst)
        rise_now |-> (gap_q >= GAP_MAX));

    p_shutdown_gate_low_r9: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd3) |-> !gate_o);

    p_ovp_enters_shutdown_r9: assert property (@(posedge clk) disable iff (rst)
        ((mode_o == 2'd1 || mode_o == 2'd2) && !gate_o && ovp_i && vdd_hold_ok)
        |=> (mode_o == 2'd3));

    p_shutdown_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        ((mode_o == 2'd3) && vdd_hold_ok) |=> (mode_o == 2'd3));

    p_supply_loss_r10: assert property (@(posedge clk) disable iff (rst)
        !vdd_hold_ok |=> ((mode_o == 2'd0) && !gate_o));
endmodule

bind qr_gate_ctrl qr_gate_ctrl_chk #(
    .MIN_PERIOD_CYC (MIN_PERIOD_CYC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .vdd_hold_ok (vdd_hold_ok),
    .ovp_i       (ovp_i),
    .gate_o      (gate_o),
    .mode_o      (mode_o)
);

// File: tb/test_qr_gate_ctrl.sv
module test_qr_gate_ctrl;
    localparam int TON_W   = 6;
    localparam int BLANK   = 3;
    localparam int DETECT  = 3;
    localparam int MINP    = 20;
    localparam int RESTART = 60;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             vdd_start_ok = 1'b0;
    logic             vdd_hold_ok = 1'b0;
    logic             valley_i = 1'b0;
    logic             ocp_i = 1'b0;
    logic             ovp_i = 1'b0;
    logic [TON_W-1:0] ton_i = '0;
    logic             gate_o;
    logic [1:0]       mode_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    qr_gate_ctrl #(
        .TON_W          (TON_W),
        .BLANK_CYC      (BLANK),
        .DETECT_CYC     (DETECT),
        .MIN_PERIOD_CYC (MINP),
        .RESTART_CYC    (RESTART)
    ) i_qr_gate_ctrl (
        .clk          (clk),
        .rst          (rst),
        .vdd_start_ok (vdd_start_ok),
        .vdd_hold_ok  (vdd_hold_ok),
        .valley_i     (valley_i),
        .ocp_i        (ocp_i),
        .ovp_i        (ovp_i),
        .ton_i        (ton_i),
        .gate_o       (gate_o),
        .mode_o       (mode_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff_ton(input int t);
        return (t == 0) ? 1 : t;
    endfunction

    function automatic int exp_width(input int t, input int ocp_pos);
        int w = eff_ton(t);
        if (ocp_pos >= BLANK && ocp_pos < BLANK + DETECT && ocp_pos + 1 < w) return ocp_pos + 1;
        return w;
    endfunction

    function automatic int exp_rise(input int width, input int vpos);
        if (vpos >= width) return (vpos + 1 > MINP) ? vpos + 1 : MINP;
        return RESTART;
    endfunction

    // Starts at a falling clock edge where the gate has just risen (index 0).
    // Returns the high width and the index of the next rise.
    task automatic run_cycle(input int vpos, input int ocp_pos, input int ovp_pos,
                             input int ton_next, output int width, output int rise);
        width = -1;
        rise  = -1;
        for (int k = 0; k < 300; k++) begin
            if (k > 0 && gate_o && width >= 0) begin
                rise = k;
                break;
            end
            if (!gate_o && width < 0) width = k;
            if (k == 0) ton_i = TON_W'(ton_next);
            valley_i = (k == vpos);
            ocp_i    = (k == ocp_pos);
            ovp_i    = (k == ovp_pos);
            @(negedge clk);
        end
        valley_i = 1'b0;
        ocp_i    = 1'b0;
        ovp_i    = 1'b0;
    endtask

    task automatic count_to_rise(output int n, output int mode_first);
        n = 0;
        mode_first = -1;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) mode_first = int'(mode_o);
        end while (!gate_o && n < 500);
    endtask

    initial begin
        int w, r, n, m, cur_ton, highs;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(gate_o == 1'b0, "R1 gate after reset", int'(gate_o), 0);
        check(mode_o == 2'd0, "R1 mode after reset", int'(mode_o), 0);
        vdd_hold_ok = 1'b1;
        highs = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (gate_o || mode_o != 2'd0) highs++;
        end
        check(highs == 0, "R1 held in standby without start flag", highs, 0);

        // R2: startup from restart timer
        ton_i = TON_W'(4);
        vdd_start_ok = 1'b1;
        count_to_rise(n, m);
        vdd_start_ok = 1'b0;
        check(m == 1, "R2 mode after start flag", m, 1);
        check(n == RESTART + 1, "R2 first turn-on delay", n, RESTART + 1);
        cur_ton = 4;

        // R3 / R2: on-time sweep on the restart timer
        for (int t = 0; t <= 10; t++) begin
            run_cycle(-1, -1, -1, t, w, r);
            check(w == eff_ton(cur_ton), "R3 on-time width", w, eff_ton(cur_ton));
            check(r == RESTART, "R2 restart period", r, RESTART);
            check(mode_o == 2'd1, "R2 mode stays startup", int'(mode_o), 1);
            cur_ton = t;
        end

        // R6: valley while gate high is ignored
        run_cycle(3, -1, -1, 5, w, r);
        check(r == RESTART, "R6 valley during high ignored", r, RESTART);
        check(mode_o == 2'd1, "R6 mode unchanged", int'(mode_o), 1);
        cur_ton = 5;

        // R4 / R5: valley position sweep
        for (int v = 5; v <= 40; v++) begin
            run_cycle(v, -1, -1, 5, w, r);
            check(w == eff_ton(cur_ton), "R3 width in valley mode", w, eff_ton(cur_ton));
            if (v + 1 >= MINP)
                check(r == exp_rise(w, v), "R4 valley turn-on", r, exp_rise(w, v));
            else
                check(r == exp_rise(w, v), "R5 early valley held to min period", r, exp_rise(w, v));
            check(mode_o == 2'd2, "R4 valley mode", int'(mode_o), 2);
        end

        // R8: no valley in valley mode
        run_cycle(-1, -1, -1, 12, w, r);
        check(r == RESTART, "R8 fallback restart in valley mode", r, RESTART);
        check(mode_o == 2'd2, "R8 mode stays valley", int'(mode_o), 2);
        cur_ton = 12;

        // R7: over-current pulse position sweep
        for (int j = 0; j <= 10; j++) begin
            run_cycle(25, j, -1, 12, w, r);
            check(w == exp_width(cur_ton, j), "R7 over-current window", w, exp_width(cur_ton, j));
            check(r == exp_rise(w, 25), "R7 next turn-on", r, exp_rise(w, 25));
        end

        // R9: over-voltage while gate high ignored
        run_cycle(25, -1, 2, 12, w, r);
        check(w == 12, "R9 ovp during high: width", w, 12);
        check(r == 26, "R9 ovp during high: next turn-on", r, 26);
        check(mode_o == 2'd2, "R9 ovp during high: mode", int'(mode_o), 2);

        // R9: valley and over-voltage in the same gate-low cycle
        repeat (15) @(negedge clk);
        valley_i = 1'b1;
        ovp_i = 1'b1;
        @(negedge clk);
        valley_i = 1'b0;
        ovp_i = 1'b0;
        check(mode_o == 2'd3, "R9 shutdown on ovp", int'(mode_o), 3);
        check(gate_o == 1'b0, "R9 gate low in shutdown", int'(gate_o), 0);
        highs = 0;
        for (int i = 0; i < 3 * RESTART; i++) begin
            @(negedge clk);
            if (gate_o) highs++;
            if (i == 5) valley_i = 1'b1;
            else valley_i = 1'b0;
        end
        check(highs == 0, "R9 no switching while shut down", highs, 0);
        check(mode_o == 2'd3, "R9 shutdown latched", int'(mode_o), 3);

        // R10: supply loss exits shutdown, restart re-times
        vdd_hold_ok = 1'b0;
        @(negedge clk);
        check(mode_o == 2'd0, "R10 standby after supply loss", int'(mode_o), 0);
        vdd_hold_ok = 1'b1;
        vdd_start_ok = 1'b1;
        count_to_rise(n, m);
        vdd_start_ok = 1'b0;
        check(n == RESTART + 1, "R10 re-timed first turn-on", n, RESTART + 1);

        // R10: supply loss while gate high
        vdd_hold_ok = 1'b0;
        @(negedge clk);
        check(gate_o == 1'b0, "R10 gate drops on supply loss", int'(gate_o), 0);
        check(mode_o == 2'd0, "R10 mode on supply loss", int'(mode_o), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule